// File: doc/BRIEF.md
# Signed Integer Divide Peripheral

This block is a register-mapped signed divide unit that sits on a simple word-addressed bus. Software loads a dividend and a divisor into two operand registers and then sets a one-shot go bit in the control word. The unit takes a snapshot of both operands, runs an iterative restoring division that produces one quotient bit per clock, and then writes the quotient and remainder into two read-only result registers. When the results land, a completion flag goes high.

Both status flags in the control word drop in the cycle after a launch. A zero divisor does not stop the run. It still takes the full latency and then reports through a dedicated flag, with fixed result values. A launch that arrives while a division is still running throws that division away and starts again from the current operand registers. Software can poll the completion flag or wait a known number of cycles.

Top module: `hwdiv_unit`

## Requirements
- R1: After reset, the control word (offset 0x00) reads 0x0000_0008, with the completion flag set. The dividend, divisor, quotient and remainder registers all read zero.
- R2: The register offsets are: control 0x00, dividend 0x04, divisor 0x08, quotient 0x0C and remainder 0x10. The dividend and divisor registers read back the value last written to them.
- R3: A write to the control word with bit 0 set launches a division. In the next cycle, the completion flag (bit 3) and the zero-divisor flag (bit 2) both read 0. A control write with bit 0 clear has no effect. Bit 0 always reads 0.
- R4: Bits 1 and 31:4 of the control word always read 0.
- R5: The completion flag reads 1 for the first time exactly 32 clock edges after the edge that samples the launch write, and the results are valid from that point on.
- R6: The division is signed 32-bit two's complement. The quotient truncates toward zero, and a nonzero remainder takes the sign of the dividend.
- R7: Dividing 0x8000_0000 by 0xFFFF_FFFF gives a quotient of 0x8000_0000 (wrapped) and a remainder of 0.
- R8: With a zero divisor, the run still takes the latency of R5. It then sets both the completion flag and the zero-divisor flag, writes 0xFFFF_FFFF as the quotient, and writes the dividend as the remainder.
- R9: A launch during a running division restarts it from the operand registers as they stand at that launch. Completion then follows R5, counted from the new launch.
- R10: Writes to the quotient and remainder offsets are ignored.
- R11: Operand register writes made after a launch do not change the result of that run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | ADDR_W (5) | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the addressed register (combinational) |

## Verification
The bench targets sign handling in all four quadrants. A design that took the remainder's sign from the divisor, or rounded the quotient toward minus infinity, would return wrong values for the mixed-sign cases. The bench counts cycles edge by edge, so an off-by-one step counter shows up as the completion flag rising at 31 or 33. The bench also covers the most negative dividend over minus one, and a zero divisor, where a missing override would leave the quotient sign-fixed instead of all ones. Three further tests check that the unit copies its operands at launch:
- a restart in mid-run;
- an operand write during a run;
- writes to the result offsets.

A unit that read live operands or let result writes through would fail these.

// File: rtl/hwdiv_pkg.sv
package hwdiv_pkg;
    localparam int unsigned WORD_W = 32;

    localparam int unsigned OFS_CTRL = 'h00;
    localparam int unsigned OFS_DVD  = 'h04;
    localparam int unsigned OFS_DSR  = 'h08;
    localparam int unsigned OFS_QUO  = 'h0C;
    localparam int unsigned OFS_REM  = 'h10;

    localparam int unsigned GO_BIT   = 0;
    localparam int unsigned DZ_BIT   = 2;
    localparam int unsigned DONE_BIT = 3;
endpackage

// File: rtl/hwdiv_cond_neg.sv
module hwdiv_cond_neg #(
    parameter int unsigned W = hwdiv_pkg::WORD_W
) (
    input  logic         neg_i,
    input  logic [W-1:0] val_i,
    output logic [W-1:0] val_o
);
    always_comb begin
        val_o = neg_i ? (~val_i + W'(1)) : val_i;
    end
endmodule

// File: rtl/hwdiv_iter.sv
module hwdiv_iter #(
    parameter int unsigned W = hwdiv_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] dvd_i,
    input  logic [W-1:0] dsr_i,
    output logic         done_o,
    output logic         dz_o,
    output logic [W-1:0] quo_o,
    output logic [W-1:0] rem_o
);
    localparam int unsigned CW   = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
        logic [W-1:0]  rem;
        logic [W-1:0]  quo;
        logic [W-1:0]  dsr;
        logic          neg_q;
        logic          neg_r;
        logic          dz;
        logic [W-1:0]  dvd_raw;
    } st_t;

    st_t st_d, st_q;

    logic [W-1:0] abs_a, abs_b, fix_q, fix_r;

    // operand magnitudes and result sign fix-up share one negator shape
    hwdiv_cond_neg #(.W(W)) u_abs_a (.neg_i(dvd_i[W-1]), .val_i(dvd_i), .val_o(abs_a));
    hwdiv_cond_neg #(.W(W)) u_abs_b (.neg_i(dsr_i[W-1]), .val_i(dsr_i), .val_o(abs_b));
    hwdiv_cond_neg #(.W(W)) u_fix_q (.neg_i(st_q.neg_q), .val_i(st_q.quo), .val_o(fix_q));
    hwdiv_cond_neg #(.W(W)) u_fix_r (.neg_i(st_q.neg_r), .val_i(st_q.rem), .val_o(fix_r));

    // one restoring step: shift in the next dividend bit, try to subtract
    function automatic logic [2*W-1:0] step(input logic [W-1:0] rem,
                                            input logic [W-1:0] quo,
                                            input logic [W-1:0] dsr);
        logic [W:0] trial;
        logic [W:0] diff;
        logic [W-1:0] r_n;
        logic         bit_n;
        trial = {rem, quo[W-1]};
        diff  = trial - {1'b0, dsr};
        if (!diff[W]) begin
            r_n   = diff[W-1:0];
            bit_n = 1'b1;
        end else begin
            r_n   = trial[W-1:0];
            bit_n = 1'b0;
        end
        return {r_n, quo[W-2:0], bit_n};
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (start_i) begin
            // the first step is folded into the load cycle
            {st_d.rem, st_d.quo} = step('0, abs_a, abs_b);
            st_d.busy    = 1'b1;
            st_d.cnt     = CW'(1);
            st_d.dsr     = abs_b;
            st_d.neg_q   = dvd_i[W-1] ^ dsr_i[W-1];
            st_d.neg_r   = dvd_i[W-1];
            st_d.dz      = (dsr_i == '0);
            st_d.dvd_raw = dvd_i;
        end else if (st_q.busy) begin
            {st_d.rem, st_d.quo} = step(st_q.rem, st_q.quo, st_q.dsr);
            st_d.cnt = st_q.cnt + CW'(1);
            if (st_q.cnt == LAST) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_o = st_q.done;
    assign dz_o   = st_q.dz;
    assign quo_o  = st_q.dz ? '1 : fix_q;
    assign rem_o  = st_q.dz ? st_q.dvd_raw : fix_r;

    // R5
    core_busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (st_q.busy && !done_o));

    // R5
    core_done_follows_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(st_q.busy));
endmodule

// File: rtl/hwdiv_unit.sv
module hwdiv_unit #(
    parameter int unsigned ADDR_W = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [hwdiv_pkg::WORD_W-1:0] wdata,
    output logic [hwdiv_pkg::WORD_W-1:0] rdata
);
    import hwdiv_pkg::*;

    localparam int unsigned W = WORD_W;
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_DVD  = ADDR_W'(OFS_DVD);
    localparam logic [ADDR_W-1:0] A_DSR  = ADDR_W'(OFS_DSR);
    localparam logic [ADDR_W-1:0] A_QUO  = ADDR_W'(OFS_QUO);
    localparam logic [ADDR_W-1:0] A_REM  = ADDR_W'(OFS_REM);
    localparam logic [W-1:0] CTRL_RO_MASK = (W'(1) << DONE_BIT) | (W'(1) << DZ_BIT);

    typedef struct packed {
        logic [W-1:0] dvd;
        logic [W-1:0] dsr;
        logic [W-1:0] quo;
        logic [W-1:0] rem;
        logic         done;
        logic         dz;
    } regs_t;

    regs_t rg_d, rg_q;

    logic         go;
    logic         core_done, core_dz;
    logic [W-1:0] core_quo, core_rem;

    assign go = wr_en && (addr == A_CTRL) && wdata[GO_BIT];

    hwdiv_iter #(.W(W)) u_iter (
        .clk    (clk),
        .rst_n  (rst_n),
        .start_i(go),
        .dvd_i  (rg_q.dvd),
        .dsr_i  (rg_q.dsr),
        .done_o (core_done),
        .dz_o   (core_dz),
        .quo_o  (core_quo),
        .rem_o  (core_rem)
    );

    always_comb begin
        rg_d = rg_q;
        if (wr_en && addr == A_DVD) rg_d.dvd = wdata;
        if (wr_en && addr == A_DSR) rg_d.dsr = wdata;
        if (go) begin
            rg_d.done = 1'b0;
            rg_d.dz   = 1'b0;
        end else if (core_done) begin
            rg_d.quo  = core_quo;
            rg_d.rem  = core_rem;
            rg_d.done = 1'b1;
            rg_d.dz   = core_dz;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q      <= '0;
            rg_q.done <= 1'b1;
        end else begin
            rg_q <= rg_d;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CTRL: begin
                rdata[DONE_BIT] = rg_q.done;
                rdata[DZ_BIT]   = rg_q.dz;
            end
            A_DVD:   rdata = rg_q.dvd;
            A_DSR:   rdata = rg_q.dsr;
            A_QUO:   rdata = rg_q.quo;
            A_REM:   rdata = rg_q.rem;
            default: rdata = '0;
        endcase
    end

    // R3
    start_clears_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (!rg_q.done && !rg_q.dz));

    // R8
    zero_implies_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rg_q.dz |-> rg_q.done);

    // R10
    result_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == A_QUO || addr == A_REM) && !core_done)
            |=> ($stable(rg_q.quo) && $stable(rg_q.rem)));

    // R4
    ctrl_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_CTRL) |-> ((rdata & ~CTRL_RO_MASK) == '0));

    // R5
    done_from_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rg_q.done) |-> $past(core_done));
endmodule

// File: tb/tb_hwdiv_unit.sv
module tb_hwdiv_unit;
    localparam int unsigned ADDR_W = 5;
    localparam int unsigned LAT    = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rdata;

    int checks = 0;
    int errors = 0;

    hwdiv_unit #(.ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1;
        d = rdata;
    endtask

    // called right after the launch write returns (half a cycle after the sampling edge)
    task automatic watch_latency(input string req);
        logic ok;
        ok = 1'b1;
        addr = 5'h00;
        #1;
        if (rdata !== 32'h0) ok = 1'b0;
        for (int i = 1; i <= LAT; i++) begin
            @(negedge clk);
            addr = 5'h00;
            #1;
            if ((i < LAT) && rdata[3]) ok = 1'b0;
            if ((i == LAT) && !rdata[3]) ok = 1'b0;
        end
        chk(req, {31'h0, ok}, 32'h1);
    endtask

    task automatic expect_div(input logic [31:0] a, input logic [31:0] b,
                              output logic [31:0] eq, output logic [31:0] er,
                              output logic [31:0] ec);
        logic signed [31:0] sa, sb;
        sa = a; sb = b;
        if (b == 32'h0) begin
            eq = 32'hFFFF_FFFF; er = a; ec = 32'hC;
        end else if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) begin
            eq = 32'h8000_0000; er = 32'h0; ec = 32'h8;
        end else begin
            eq = sa / sb; er = sa % sb; ec = 32'h8;
        end
    endtask

    task automatic check_results(input string req, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] eq, er, ec, v;
        expect_div(a, b, eq, er, ec);
        rd(5'h0C, v); chk({req, " quotient"}, v, eq);
        rd(5'h10, v); chk({req, " remainder"}, v, er);
        rd(5'h00, v); chk({req, " control"}, v, ec);
    endtask

    task automatic t_divide(input logic [31:0] a, input logic [31:0] b, input string req);
        wr(5'h04, a);
        wr(5'h08, b);
        wr(5'h00, 32'h1);
        watch_latency({req, " R5 latency"});
        check_results(req, a, b);
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(5'h00, v); chk("R1 ctrl reset", v, 32'h8);
        rd(5'h04, v); chk("R1 dividend reset", v, 32'h0);
        rd(5'h08, v); chk("R1 divisor reset", v, 32'h0);
        rd(5'h0C, v); chk("R1 quotient reset", v, 32'h0);
        rd(5'h10, v); chk("R1 remainder reset", v, 32'h0);
    endtask

    task automatic t_offsets;
        logic [31:0] v;
        wr(5'h04, 32'hA5A5_0001);
        wr(5'h08, 32'h0000_5A5A);
        rd(5'h04, v); chk("R2 dividend readback", v, 32'hA5A5_0001);
        rd(5'h08, v); chk("R2 divisor readback", v, 32'h0000_5A5A);
    endtask

    task automatic t_go_zero;
        logic [31:0] v;
        // control write with bit 0 clear and junk in reserved bits: no launch
        wr(5'h00, 32'hFFFF_FFFE);
        rd(5'h00, v); chk("R3 zero write keeps flags", v, 32'h8);
        for (int i = 0; i < 3; i++) @(negedge clk);
        rd(5'h00, v); chk("R4 R3 no launch later, start reads 0", v, 32'h8);
    endtask

    task automatic t_restart;
        logic [31:0] v;
        wr(5'h04, 32'd100);
        wr(5'h08, 32'd7);
        wr(5'h00, 32'h1);
        for (int i = 0; i < 10; i++) @(negedge clk);
        rd(5'h00, v); chk("R9 busy mid run", v, 32'h0);
        wr(5'h08, 32'd3);
        wr(5'h04, 32'hFFFF_FFCE);   // -50
        wr(5'h00, 32'h1);
        watch_latency("R9 restart latency");
        check_results("R9 restart", 32'hFFFF_FFCE, 32'd3);
    endtask

    task automatic t_snapshot;
        wr(5'h04, 32'd1000);
        wr(5'h08, 32'd10);
        wr(5'h00, 32'h1);
        wr(5'h04, 32'd7);
        wr(5'h08, 32'd2);
        for (int i = 0; i < LAT; i++) @(negedge clk);
        check_results("R11 snapshot", 32'd1000, 32'd10);
    endtask

    task automatic t_ro_write;
        logic [31:0] v;
        t_divide(32'd77, 32'd5, "R6 setup");
        wr(5'h0C, 32'hDEAD_BEEF);
        wr(5'h10, 32'hCAFE_F00D);
        rd(5'h0C, v); chk("R10 quotient write ignored", v, 32'd15);
        rd(5'h10, v); chk("R10 remainder write ignored", v, 32'd2);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_offsets();
        t_go_zero();
        t_divide(32'd100, 32'd7, "R6 pos/pos");
        t_divide(32'hFFFF_FF9C, 32'd7, "R6 neg/pos");
        t_divide(32'd100, 32'hFFFF_FFF9, "R6 pos/neg");
        t_divide(32'hFFFF_FF9C, 32'hFFFF_FFF9, "R6 neg/neg");
        t_divide(32'd5, 32'd9, "R6 small dividend");
        t_divide(32'h7FFF_FFFF, 32'd1, "R6 max by one");
        t_divide(32'h8000_0000, 32'd2, "R6 min by two");
        t_divide(32'h8000_0000, 32'h8000_0000, "R6 min by min");
        t_divide(32'h8000_0000, 32'hFFFF_FFFF, "R7 overflow");
        t_divide(32'hFFFF_FFD3, 32'd0, "R8 zero divisor");
        t_divide(32'd12, 32'd4, "R3 flags clear after zero run");
        t_restart();
        t_snapshot();
        t_ro_write();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule